// File: doc/BRIEF.md
# Region-Based Memory Protection Checker

This block guards a processor's memory accesses with eight programmable address windows. Each window has an inclusive lower and upper address at 32-byte granularity, an access-permission code, an execute-never flag and a 3-bit pointer into a table of eight packed memory-attribute bytes. For every access presented on the request side (address, write flag, instruction-fetch flag, privilege level, fault-handler context flag), the block returns a combinational fault decision and the attribute byte of the window that was hit.

Software programs the windows through a small word-indexed register port. A select register picks which window the base and limit registers show. A control register turns checking on, keeps checking alive inside fault-handler and non-maskable interrupt context, and lets privileged accesses that hit no window fall through to a default map. Windows must never overlap. An address that lands in two enabled windows at once is treated as a fault; no window takes priority.

Top module: `mpu_guard`

## Requirements
- R1: Word index 0 is read-only and reads 0x00000800: the window count 8 in bits [15:8] and 0 in bit 0. Writes to it have no effect.
- R2: Word index 1 is the control register. It resets to 0 and keeps only bits [2:0]: bit 0 turns checking on, bit 1 keeps checking on in fault-handler context, and bit 2 lets privileged accesses that hit no window through. Bits [31:3] read 0.
- R3: Word index 2 holds a window number in bits [7:0]. Word index 3 (base) and word index 4 (limit) read and write the window it names. When the number is 8 or higher, writes to base and limit change nothing and reads return 0.
- R4: The base register has the start address in [31:5], a shareability code in [4:3], the permission code in [2:1] and execute-never in bit 0. The limit register has the end address in [31:5], the attribute pointer in [3:1] and the window enable in bit 0. Limit bit 4 always reads 0. All window registers and both attribute words reset to 0.
- R5: An enabled window is hit when addr[31:5] lies between base[31:5] and limit[31:5], both ends included, so the window ends at the limit with its low five bits all ones.
- R6: Permission code: 00 allows read and write for privileged code only, 01 allows read and write for any level, 10 allows read only for privileged code only, and 11 allows read only for any level. A write to a read-only window faults. An unprivileged access to a privileged-only window faults.
- R7: An instruction fetch that hits a window with execute-never set faults.
- R8: An access that hits two or more enabled windows faults and returns attribute 0.
- R9: An access that hits no window, while checking is on, is permitted only if it is privileged and control bit 2 is set. Otherwise it faults. In both cases the attribute is 0.
- R10: When control bit 0 is clear, or when the fault-context flag is set and control bit 1 is clear, every access is permitted with attribute 0.
- R11: When exactly one window is hit, the attribute output is byte (p mod 4) of attribute word p/4, where p is that window's pointer. Attribute word 0 is at index 5 and attribute word 1 is at index 6, and byte 0 is bits [7:0]. This holds whether or not the access faults.
- R12: The fault and attribute outputs follow the request inputs in the same cycle. A register write changes them only from the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_idx | input | 3 | Register word index |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_idx (combinational) |
| acc_addr | input | 32 | Access address |
| acc_write | input | 1 | Access is a write |
| acc_fetch | input | 1 | Access is an instruction fetch |
| acc_priv | input | 1 | Access is privileged |
| acc_fault_ctx | input | 1 | Access is made from fault-handler or NMI context |
| acc_fault | output | 1 | Access is refused |
| acc_attr | output | 8 | Attribute byte of the single window hit, else 0 |

## Verification
The first set of tests is directed. It places accesses on both sides of a window's first and last 32-byte granule, so an exclusive bound or an unmasked limit shows up. It sends writes, fetches and unprivileged reads to a privileged read-only, execute-never window, so each permission term is seen failing on its own. It also places two windows that share a granule, so an overlap taken as a priority win is told apart from one taken as a fault. The unmatched case is tried privileged and unprivileged, with the default map on and off. Fault-handler context is tried with control bit 1 clear and set, which separates the two meanings of "checking on". The second set is random. It reprograms all eight windows many times inside a small address span with random permission codes, pointers, enables and control values. Each random access is compared with a model in the bench, so hits, misses, overlaps and every attribute byte position occur in many combinations.

// File: rtl/mpu_guard_pkg.sv
package mpu_guard_pkg;

  localparam int ADDR_W  = 32;
  localparam int GRAN_W  = 5;
  localparam int PAGE_W  = ADDR_W - GRAN_W;
  localparam int APTR_W  = 3;
  localparam int ATTR_W  = 8;

  typedef enum logic [2:0] {
    W_TYPE  = 3'd0,
    W_CTRL  = 3'd1,
    W_SEL   = 3'd2,
    W_BASE  = 3'd3,
    W_LIMIT = 3'd4,
    W_ATTR0 = 3'd5,
    W_ATTR1 = 3'd6
  } word_e;

  typedef struct packed {
    logic [PAGE_W-1:0] start;
    logic [1:0]        share;
    logic [1:0]        perm;
    logic              no_exec;
  } base_t;

  typedef struct packed {
    logic [PAGE_W-1:0] stop;
    logic              rsv;
    logic [APTR_W-1:0] aptr;
    logic              on;
  } lim_t;

  // Inclusive window test on 32-byte granules.
  function automatic logic in_window(logic [PAGE_W-1:0] page,
                                     logic [PAGE_W-1:0] lo,
                                     logic [PAGE_W-1:0] hi,
                                     logic              on);
    return on && (page >= lo) && (page <= hi);
  endfunction

  // Permission outcome for one hit window.
  function automatic logic perm_ok(logic [1:0] perm, logic no_exec,
                                   logic wr, logic fetch, logic priv);
    logic ok;
    ok = 1'b1;
    if (fetch && no_exec) ok = 1'b0;
    if (wr && perm[1])    ok = 1'b0;
    if (!priv && !perm[0]) ok = 1'b0;
    return ok;
  endfunction

  // Pick attribute byte aptr out of the two packed attribute words.
  function automatic logic [ATTR_W-1:0] attr_pick(logic [2*32-1:0] words,
                                                  logic [APTR_W-1:0] aptr);
    return words[{aptr, 3'b000} +: ATTR_W];
  endfunction

endpackage

// File: rtl/mpu_guard_regs.sv
module mpu_guard_regs
  import mpu_guard_pkg::*;
#(
  parameter int NUM_REGIONS = 8
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   cfg_wr,
  input  logic [2:0]                             cfg_idx,
  input  logic [31:0]                            cfg_wdata,
  output logic [31:0]                            cfg_rdata,
  output logic [2:0]                             ctrl_bits,
  output logic [NUM_REGIONS-1:0][PAGE_W-1:0]     rg_lo,
  output logic [NUM_REGIONS-1:0][PAGE_W-1:0]     rg_hi,
  output logic [NUM_REGIONS-1:0]                 rg_on,
  output logic [NUM_REGIONS-1:0][1:0]            rg_perm,
  output logic [NUM_REGIONS-1:0]                 rg_nx,
  output logic [NUM_REGIONS-1:0][APTR_W-1:0]     rg_aptr,
  output logic [63:0]                            attr_words
);

  localparam int         SEL_W  = $clog2(NUM_REGIONS);
  localparam logic [7:0] NREG8  = 8'(NUM_REGIONS);
  localparam logic [31:0] TYPE_VAL = {16'h0000, NREG8, 8'h00};

  logic [2:0]  ctrl_q;
  logic [7:0]  sel_q;
  logic [31:0] attr_q [2];
  base_t       base_q [NUM_REGIONS];
  lim_t        lim_q  [NUM_REGIONS];

  logic             sel_ok;
  logic [SEL_W-1:0] sel_idx;

  assign sel_ok  = (sel_q < NREG8);
  assign sel_idx = sel_q[SEL_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      sel_q     <= '0;
      attr_q[0] <= '0;
      attr_q[1] <= '0;
    end else if (cfg_wr) begin
      case (cfg_idx)
        W_CTRL:  ctrl_q    <= cfg_wdata[2:0];
        W_SEL:   sel_q     <= cfg_wdata[7:0];
        W_ATTR0: attr_q[0] <= cfg_wdata;
        W_ATTR1: attr_q[1] <= cfg_wdata;
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_win
    logic pick;
    assign pick = cfg_wr && sel_ok && (sel_idx == SEL_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        base_q[g] <= '0;
        lim_q[g]  <= '0;
      end else if (pick) begin
        if (cfg_idx == W_BASE)  base_q[g] <= base_t'(cfg_wdata);
        if (cfg_idx == W_LIMIT) lim_q[g]  <= lim_t'({cfg_wdata[31:5], 1'b0, cfg_wdata[3:0]});
      end
    end

    assign rg_lo[g]   = base_q[g].start;
    assign rg_perm[g] = base_q[g].perm;
    assign rg_nx[g]   = base_q[g].no_exec;
    assign rg_hi[g]   = lim_q[g].stop;
    assign rg_aptr[g] = lim_q[g].aptr;
    assign rg_on[g]   = lim_q[g].on;
  end

  always_comb begin
    cfg_rdata = '0;
    case (cfg_idx)
      W_TYPE:  cfg_rdata = TYPE_VAL;
      W_CTRL:  cfg_rdata = {29'b0, ctrl_q};
      W_SEL:   cfg_rdata = {24'b0, sel_q};
      W_BASE:  if (sel_ok) cfg_rdata = base_q[sel_idx];
      W_LIMIT: if (sel_ok) cfg_rdata = lim_q[sel_idx];
      W_ATTR0: cfg_rdata = attr_q[0];
      W_ATTR1: cfg_rdata = attr_q[1];
      default: cfg_rdata = '0;
    endcase
  end

  assign ctrl_bits  = ctrl_q;
  assign attr_words = {attr_q[1], attr_q[0]};

endmodule

// File: rtl/mpu_guard_match.sv
module mpu_guard_match
  import mpu_guard_pkg::*;
#(
  parameter int NUM_REGIONS = 8
) (
  input  logic [ADDR_W-1:0]                  acc_addr,
  input  logic [NUM_REGIONS-1:0][PAGE_W-1:0] rg_lo,
  input  logic [NUM_REGIONS-1:0][PAGE_W-1:0] rg_hi,
  input  logic [NUM_REGIONS-1:0]             rg_on,
  output logic [NUM_REGIONS-1:0]             hit_vec
);

  logic [PAGE_W-1:0] page;
  assign page = acc_addr[ADDR_W-1:GRAN_W];

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_cmp
    assign hit_vec[g] = in_window(page, rg_lo[g], rg_hi[g], rg_on[g]);
  end

  logic unused_low;
  assign unused_low = ^acc_addr[GRAN_W-1:0];

endmodule

// File: rtl/mpu_guard_decide.sv
module mpu_guard_decide
  import mpu_guard_pkg::*;
#(
  parameter int NUM_REGIONS = 8
) (
  input  logic [NUM_REGIONS-1:0]             hit_vec,
  input  logic [NUM_REGIONS-1:0][1:0]        rg_perm,
  input  logic [NUM_REGIONS-1:0]             rg_nx,
  input  logic [NUM_REGIONS-1:0][APTR_W-1:0] rg_aptr,
  input  logic [63:0]                        attr_words,
  input  logic [2:0]                         ctrl_bits,
  input  logic                               acc_write,
  input  logic                               acc_fetch,
  input  logic                               acc_priv,
  input  logic                               acc_fault_ctx,
  output logic                               acc_fault,
  output logic [ATTR_W-1:0]                  acc_attr,
  output logic                               check_active,
  output logic [1:0]                         match_perm,
  output logic                               match_nx
);

  localparam int CNT_W = $clog2(NUM_REGIONS + 1);

  logic [CNT_W-1:0]  hit_cnt;
  logic [APTR_W-1:0] match_aptr;

  assign check_active = ctrl_bits[0] && (!acc_fault_ctx || ctrl_bits[1]);

  // Merge the fields of hit windows; meaningful when exactly one hits.
  always_comb begin
    hit_cnt    = '0;
    match_perm = '0;
    match_nx   = 1'b0;
    match_aptr = '0;
    for (int i = 0; i < NUM_REGIONS; i++) begin
      hit_cnt = hit_cnt + CNT_W'(hit_vec[i]);
      if (hit_vec[i]) begin
        match_perm = match_perm | rg_perm[i];
        match_nx   = match_nx   | rg_nx[i];
        match_aptr = match_aptr | rg_aptr[i];
      end
    end
  end

  always_comb begin
    acc_fault = 1'b0;
    acc_attr  = '0;
    if (check_active) begin
      if (hit_cnt == CNT_W'(0)) begin
        acc_fault = !(ctrl_bits[2] && acc_priv);
      end else if (hit_cnt == CNT_W'(1)) begin
        acc_fault = !perm_ok(match_perm, match_nx, acc_write, acc_fetch, acc_priv);
        acc_attr  = attr_pick(attr_words, match_aptr);
      end else begin
        acc_fault = 1'b1;
      end
    end
  end

endmodule

// File: rtl/mpu_guard.sv
module mpu_guard
  import mpu_guard_pkg::*;
#(
  parameter int NUM_REGIONS = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr,
  input  logic [2:0]  cfg_idx,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic [31:0] acc_addr,
  input  logic        acc_write,
  input  logic        acc_fetch,
  input  logic        acc_priv,
  input  logic        acc_fault_ctx,
  output logic        acc_fault,
  output logic [7:0]  acc_attr
);

  logic [2:0]                             ctrl_bits;
  logic [NUM_REGIONS-1:0][PAGE_W-1:0]     rg_lo;
  logic [NUM_REGIONS-1:0][PAGE_W-1:0]     rg_hi;
  logic [NUM_REGIONS-1:0]                 rg_on;
  logic [NUM_REGIONS-1:0][1:0]            rg_perm;
  logic [NUM_REGIONS-1:0]                 rg_nx;
  logic [NUM_REGIONS-1:0][APTR_W-1:0]     rg_aptr;
  logic [63:0]                            attr_words;
  logic [NUM_REGIONS-1:0]                 hit_vec;
  logic                                   check_active;
  logic [1:0]                             match_perm;
  logic                                   match_nx;

  mpu_guard_regs #(.NUM_REGIONS(NUM_REGIONS)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_wr     (cfg_wr),
    .cfg_idx    (cfg_idx),
    .cfg_wdata  (cfg_wdata),
    .cfg_rdata  (cfg_rdata),
    .ctrl_bits  (ctrl_bits),
    .rg_lo      (rg_lo),
    .rg_hi      (rg_hi),
    .rg_on      (rg_on),
    .rg_perm    (rg_perm),
    .rg_nx      (rg_nx),
    .rg_aptr    (rg_aptr),
    .attr_words (attr_words)
  );

  mpu_guard_match #(.NUM_REGIONS(NUM_REGIONS)) u_match (
    .acc_addr (acc_addr),
    .rg_lo    (rg_lo),
    .rg_hi    (rg_hi),
    .rg_on    (rg_on),
    .hit_vec  (hit_vec)
  );

  mpu_guard_decide #(.NUM_REGIONS(NUM_REGIONS)) u_decide (
    .hit_vec       (hit_vec),
    .rg_perm       (rg_perm),
    .rg_nx         (rg_nx),
    .rg_aptr       (rg_aptr),
    .attr_words    (attr_words),
    .ctrl_bits     (ctrl_bits),
    .acc_write     (acc_write),
    .acc_fetch     (acc_fetch),
    .acc_priv      (acc_priv),
    .acc_fault_ctx (acc_fault_ctx),
    .acc_fault     (acc_fault),
    .acc_attr      (acc_attr),
    .check_active  (check_active),
    .match_perm    (match_perm),
    .match_nx      (match_nx)
  );

endmodule

// File: rtl/mpu_guard_chk.sv
module mpu_guard_chk #(
  parameter int NUM_REGIONS = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   cfg_wr,
  input logic [2:0]             cfg_idx,
  input logic [2:0]             wr_low,
  input logic [31:0]            cfg_rdata,
  input logic                   acc_write,
  input logic                   acc_fetch,
  input logic                   acc_priv,
  input logic                   acc_fault_ctx,
  input logic                   acc_fault,
  input logic [7:0]             acc_attr,
  input logic [2:0]             ctrl_bits,
  input logic [NUM_REGIONS-1:0] hits,
  input logic [1:0]             match_perm,
  input logic                   match_nx
);

  logic live;
  assign live = ctrl_bits[0] && (!acc_fault_ctx || ctrl_bits[1]);

  // R1: type word is constant
  a_r1_type_word: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_idx == 3'd0) |-> (cfg_rdata == {16'h0, 8'(NUM_REGIONS), 8'h00}));

  // R12: control write visible after the edge
  a_r12_ctrl_next_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_idx == 3'd1) |=> (ctrl_bits == $past(wr_low)));

  // R10: bypass permits everything
  a_r10_bypass_permit: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_bits[0] || (acc_fault_ctx && !ctrl_bits[1])) |-> (!acc_fault && acc_attr == 8'h00));

  // R8: overlap faults
  a_r8_overlap_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (live && $countones(hits) > 1) |-> (acc_fault && acc_attr == 8'h00));

  // R9: unmatched unprivileged always faults, privileged passes with map on
  a_r9_miss_unpriv: assert property (@(posedge clk) disable iff (!rst_n)
    (live && hits == '0 && !acc_priv) |-> acc_fault);
  a_r9_miss_priv_map: assert property (@(posedge clk) disable iff (!rst_n)
    (live && hits == '0 && acc_priv && ctrl_bits[2]) |-> (!acc_fault && acc_attr == 8'h00));

  // R7: execute-never fetch
  a_r7_nx_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    (live && $countones(hits) == 1 && match_nx && acc_fetch) |-> acc_fault);

  // R6: read-only write and privileged-only from user
  a_r6_ro_write: assert property (@(posedge clk) disable iff (!rst_n)
    (live && $countones(hits) == 1 && match_perm[1] && acc_write) |-> acc_fault);
  a_r6_user_denied: assert property (@(posedge clk) disable iff (!rst_n)
    (live && $countones(hits) == 1 && !match_perm[0] && !acc_priv) |-> acc_fault);

endmodule

bind mpu_guard mpu_guard_chk #(.NUM_REGIONS(NUM_REGIONS)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_wr        (cfg_wr),
  .cfg_idx       (cfg_idx),
  .wr_low        (cfg_wdata[2:0]),
  .cfg_rdata     (cfg_rdata),
  .acc_write     (acc_write),
  .acc_fetch     (acc_fetch),
  .acc_priv      (acc_priv),
  .acc_fault_ctx (acc_fault_ctx),
  .acc_fault     (acc_fault),
  .acc_attr      (acc_attr),
  .ctrl_bits     (ctrl_bits),
  .hits          (hit_vec),
  .match_perm    (match_perm),
  .match_nx      (match_nx)
);

// File: tb/mpu_guard_bench.sv
module mpu_guard_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [2:0]  cfg_idx = 3'd0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [31:0] acc_addr = '0;
  logic        acc_write = 1'b0;
  logic        acc_fetch = 1'b0;
  logic        acc_priv = 1'b0;
  logic        acc_fault_ctx = 1'b0;
  logic        acc_fault;
  logic [7:0]  acc_attr;

  int total = 0;
  int bad = 0;

  // bench-side mirror of programmed state
  logic [2:0]  m_ctrl = 3'd0;
  logic [7:0]  m_sel = 8'd0;
  logic [31:0] m_base [8];
  logic [31:0] m_lim  [8];
  logic [31:0] m_attr [2];

  always #(CLK_PERIOD/2) clk = ~clk;

  mpu_guard u_mpu_guard (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .acc_addr(acc_addr),
    .acc_write(acc_write), .acc_fetch(acc_fetch), .acc_priv(acc_priv),
    .acc_fault_ctx(acc_fault_ctx), .acc_fault(acc_fault), .acc_attr(acc_attr)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] idx, logic [31:0] data);
    @(negedge clk);
    cfg_idx = idx; cfg_wdata = data; cfg_wr = 1'b1;
    @(posedge clk); #1;
    cfg_wr = 1'b0;
    case (idx)
      3'd1: m_ctrl = data[2:0];
      3'd2: m_sel = data[7:0];
      3'd3: if (m_sel < 8) m_base[m_sel[2:0]] = data;
      3'd4: if (m_sel < 8) m_lim[m_sel[2:0]] = data & ~32'h10;
      3'd5: m_attr[0] = data;
      3'd6: m_attr[1] = data;
      default: ;
    endcase
  endtask

  task automatic rd(logic [2:0] idx, output logic [31:0] val);
    @(negedge clk);
    cfg_idx = idx; #1;
    val = cfg_rdata;
  endtask

  function automatic void model(logic [31:0] a, logic w, logic f, logic p, logic fc,
                                output logic ef, output logic [7:0] ea);
    int n; int k; logic [1:0] ap; logic nx; logic [2:0] ix;
    ef = 1'b0; ea = 8'h00; n = 0; k = 0;
    if (!m_ctrl[0] || (fc && !m_ctrl[1])) return;
    for (int i = 0; i < 8; i++) begin
      if (m_lim[i][0] && a >= (m_base[i] & 32'hFFFF_FFE0) && a <= (m_lim[i] | 32'h1F)) begin
        n++; k = i;
      end
    end
    if (n == 0) ef = !(m_ctrl[2] && p);
    else if (n > 1) ef = 1'b1;
    else begin
      ap = m_base[k][2:1]; nx = m_base[k][0]; ix = m_lim[k][3:1];
      ef = (f && nx) || (w && ap == 2'b10) || (w && ap == 2'b11) || (!p && (ap == 2'b00 || ap == 2'b10));
      ea = m_attr[ix[2]] >> (ix[1:0] * 8);
    end
  endfunction

  task automatic acc(string req, logic [31:0] a, logic w, logic f, logic p, logic fc);
    logic ef; logic [7:0] ea;
    @(negedge clk);
    acc_addr = a; acc_write = w; acc_fetch = f; acc_priv = p; acc_fault_ctx = fc;
    #1;
    model(a, w, f, p, fc, ef, ea);
    check(req, {31'b0, acc_fault}, {31'b0, ef}, "fault");
    check(req, {24'b0, acc_attr}, {24'b0, ea}, "attr");
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    bad++;
    $display("FAIL R12 watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [31:0] v;
    void'($urandom(32'd20240607));
    for (int i = 0; i < 8; i++) begin m_base[i] = '0; m_lim[i] = '0; end
    m_attr[0] = '0; m_attr[1] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // reset state
    rd(3'd0, v); check("R1", v, 32'h0000_0800, "type word");
    rd(3'd1, v); check("R2", v, 32'h0, "ctrl reset");
    rd(3'd3, v); check("R4", v, 32'h0, "base reset");
    rd(3'd4, v); check("R4", v, 32'h0, "limit reset");
    rd(3'd5, v); check("R4", v, 32'h0, "attr0 reset");
    wr(3'd0, 32'hFFFF_FFFF);
    rd(3'd0, v); check("R1", v, 32'h0000_0800, "type after write");
    wr(3'd1, 32'hFFFF_FFFF);
    rd(3'd1, v); check("R2", v, 32'h7, "ctrl masked");
    wr(3'd1, 32'h0);

    // R10: unit off
    acc("R10", 32'h1234_5678, 1'b1, 1'b1, 1'b0, 1'b0);

    // window 0: 0x30000000..0x30001FFF, priv RO, NX, pointer 2
    wr(3'd2, 32'd0);
    wr(3'd3, 32'h3000_0005);
    wr(3'd4, 32'h3000_1FF5);
    rd(3'd4, v); check("R4", v, 32'h3000_1FE5, "limit bit4 reads 0");
    rd(3'd3, v); check("R4", v, 32'h3000_0005, "base readback");
    wr(3'd5, 32'h1122_3344);
    wr(3'd1, 32'h1);
    acc("R5", 32'h3000_1FFF, 1'b0, 1'b0, 1'b1, 1'b0);
    check("R11", {24'b0, acc_attr}, 32'h22, "pointer 2 byte");
    acc("R5", 32'h3000_0000, 1'b0, 1'b0, 1'b1, 1'b0);
    acc("R5", 32'h3000_2000, 1'b0, 1'b0, 1'b1, 1'b0);
    acc("R5", 32'h2FFF_FFFF, 1'b0, 1'b0, 1'b1, 1'b0);
    acc("R6", 32'h3000_0040, 1'b1, 1'b0, 1'b1, 1'b0);
    check("R6", {31'b0, acc_fault}, 32'h1, "write to read-only");
    acc("R6", 32'h3000_0040, 1'b0, 1'b0, 1'b0, 1'b0);
    acc("R7", 32'h3000_0100, 1'b0, 1'b1, 1'b1, 1'b0);
    check("R7", {31'b0, acc_fault}, 32'h1, "fetch from NX");

    // R9: default map
    wr(3'd1, 32'h5);
    acc("R9", 32'h4000_0000, 1'b1, 1'b0, 1'b1, 1'b0);
    check("R9", {31'b0, acc_fault}, 32'h0, "priv miss with map");
    acc("R9", 32'h4000_0000, 1'b0, 1'b0, 1'b0, 1'b0);

    // R10: fault context with bit1 clear, then set
    acc("R10", 32'h3000_0040, 1'b1, 1'b0, 1'b1, 1'b1);
    check("R10", {31'b0, acc_fault}, 32'h0, "fault ctx bypass");
    wr(3'd1, 32'h7);
    acc("R10", 32'h3000_0040, 1'b1, 1'b0, 1'b1, 1'b1);

    // R8: overlapping window 1, any-level RW, pointer 5
    wr(3'd2, 32'd1);
    wr(3'd3, 32'h3000_1002);
    wr(3'd4, 32'h3000_1FEB);
    acc("R8", 32'h3000_1000, 1'b0, 1'b0, 1'b1, 1'b0);
    check("R8", {31'b0, acc_fault}, 32'h1, "overlap");
    acc("R8", 32'h3000_0FFF, 1'b0, 1'b0, 1'b1, 1'b0);

    // R3: out-of-range select
    wr(3'd2, 32'd9);
    wr(3'd3, 32'hDEAD_BEEF);
    rd(3'd3, v); check("R3", v, 32'h0, "base with select 9");
    rd(3'd4, v); check("R3", v, 32'h0, "limit with select 9");
    wr(3'd2, 32'd1);
    rd(3'd3, v); check("R3", v, 32'h3000_1002, "window 1 untouched");

    // R11: only window 1, pointer 5 -> word1 byte1
    wr(3'd2, 32'd0);
    wr(3'd4, 32'h3000_1FE4);
    wr(3'd6, 32'h9988_7766);
    acc("R11", 32'h3000_1800, 1'b1, 1'b0, 1'b0, 1'b0);
    check("R11", {24'b0, acc_attr}, 32'h77, "pointer 5 byte");

    // R12: write takes effect at next edge; window 1 is writable, make 0 RO again
    wr(3'd4, 32'h3000_0FE5);
    wr(3'd1, 32'h5);
    @(negedge clk);
    acc_addr = 32'h3000_0100; acc_write = 1'b1; acc_fetch = 1'b0; acc_priv = 1'b1; acc_fault_ctx = 1'b0;
    cfg_idx = 3'd1; cfg_wdata = 32'h0; cfg_wr = 1'b1;
    #1 check("R12", {31'b0, acc_fault}, 32'h1, "before edge");
    @(posedge clk); #1;
    cfg_wr = 1'b0; m_ctrl = 3'd0;
    check("R12", {31'b0, acc_fault}, 32'h0, "after edge");

    // random rounds
    for (int r = 0; r < 40; r++) begin
      for (int g = 0; g < 8; g++) begin
        logic [31:0] b; logic [31:0] l;
        b = 32'h3000_0000 + ($urandom & 32'h1FE0);
        l = b + ($urandom & 32'h07E0);
        wr(3'd2, g);
        wr(3'd3, b | ($urandom & 32'h1F));
        wr(3'd4, l | ($urandom & 32'h1E) | 32'(($urandom % 4) != 0));
      end
      wr(3'd5, $urandom);
      wr(3'd6, $urandom);
      wr(3'd1, 32'(($urandom % 8) | 1));
      for (int t = 0; t < 15; t++) begin
        logic [1:0] kind;
        kind = 2'($urandom);
        acc("R5/R6/R7/R8/R9/R11", 32'h3000_0000 + ($urandom & 32'h27FF),
            kind == 2'd1, kind == 2'd2, 1'($urandom), 1'($urandom % 5 == 0));
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule